// File: doc/BRIEF.md
# Switch Tail-Tag Shim

This block sits between a host-facing port and the host port of a three-port switch fabric. Both directions carry byte-wide streaming frames with valid, last and ready signals. On the path from the host toward the fabric it adds one trailing byte to each frame. That byte names the port the frame is to leave on. On the path from the fabric toward the host it removes the trailing byte of each frame. The port that byte identifies is presented as a sideband value beside the last data beat.

A single tagging-enable control bit selects between tagged operation and plain pass-through. The enable is sampled independently on each path when a frame's first beat is accepted, and it holds for the whole frame. A second control bit, the pass-all-frames flag, is not used by the datapath. It is only mirrored back as a registered status output. On the receive side the block keeps one byte in hand. When the next beat turns out to be the tag, it can raise last on the byte before it. A frame that consists of nothing but a tag is discarded and reported.

Top module: `tail_tag_shim`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_out_valid`, `rx_out_valid`, `rx_err` and `pass_all_status` are all low.
- R2: With tagging on, every transmit data byte is forwarded unchanged and with last low. It is followed by exactly one tag byte carrying last high.
- R3: The transmit tag byte has bit n set and all other bits clear when `tx_in_dest` equals n, for n below NPORTS. It is 8'h00 when `tx_in_dest` is NPORTS or more. `tx_in_dest` is sampled on the accepted final data beat.
- R4: With tagging off, transmit frames pass through byte for byte with last unchanged, and no byte is added.
- R5: With tagging on, the final received byte is removed from the frame and last moves to the byte before it. `rx_out_port` on that beat equals bits [2:0] of the removed byte, and bits [7:3] of that byte have no effect. On beats where last is low, `rx_out_port` reads 0.
- R6: With tagging on, a received frame of a single byte produces no output beat. `rx_err` is high for exactly one cycle, in the cycle after that byte is accepted.
- R7: With tagging off, received frames pass through unchanged, `rx_out_port` reads 0, and a one-byte frame is forwarded without raising `rx_err`.
- R8: Each path samples `cfg_tag_en` when it accepts the first beat of a frame. A change of `cfg_tag_en` in the middle of a frame does not alter how that frame is handled.
- R9: `pass_all_status` equals the value `cfg_pass_all` had in the previous cycle.
- R10: Under arbitrary output backpressure, no byte is lost, duplicated or reordered on either path. An output beat held back by a low ready keeps its data until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tag_en | input | 1 | Tagging enable (control bit) |
| cfg_pass_all | input | 1 | Pass-all-frames control bit |
| pass_all_status | output | 1 | Registered copy of `cfg_pass_all` |
| tx_in_data | input | 8 | Host-side transmit byte |
| tx_in_valid | input | 1 | Transmit input valid |
| tx_in_last | input | 1 | Transmit input last beat |
| tx_in_dest | input | DEST_W (2) | Destination port index, sampled on last beat |
| tx_in_ready | output | 1 | Transmit input ready |
| tx_out_data | output | 8 | Fabric-side transmit byte |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_last | output | 1 | Transmit output last beat |
| tx_out_ready | input | 1 | Transmit output ready |
| rx_in_data | input | 8 | Fabric-side receive byte |
| rx_in_valid | input | 1 | Receive input valid |
| rx_in_last | input | 1 | Receive input last beat |
| rx_in_ready | output | 1 | Receive input ready |
| rx_out_data | output | 8 | Host-side receive byte |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_last | output | 1 | Receive output last beat |
| rx_out_port | output | 3 | Source port number, valid with last |
| rx_out_ready | input | 1 | Receive output ready |
| rx_err | output | 1 | One-cycle pulse for a dropped one-byte frame |

## Verification
The bench aims at receive frames of one and two bytes. A design that miscounts the held-back byte would emit the tag as data, put last on the wrong beat, or stall on a lone tag instead of dropping it. It sends tag bytes with junk in the upper five bits, and out-of-range destination indices, so that a wide port decode or a tag that is not one-hot shows up at once. It also flips the enable in the middle of frames: a design that reads the live bit would add or drop a tag partway through a frame. Random ready stalls on both outputs, with idle gaps on the inputs, expose a byte that is lost or duplicated while the tag is pending or a byte is held.

// File: rtl/tail_tag_shim.sv
module tail_tag_shim #(
  parameter int NPORTS = 3,
  localparam int DEST_W = $clog2(NPORTS + 1),
  localparam int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tag_en,
  input  logic              cfg_pass_all,
  output logic              pass_all_status,
  input  logic [7:0]        tx_in_data,
  input  logic              tx_in_valid,
  input  logic              tx_in_last,
  input  logic [DEST_W-1:0] tx_in_dest,
  output logic              tx_in_ready,
  output logic [7:0]        tx_out_data,
  output logic              tx_out_valid,
  output logic              tx_out_last,
  input  logic              tx_out_ready,
  input  logic [7:0]        rx_in_data,
  input  logic              rx_in_valid,
  input  logic              rx_in_last,
  output logic              rx_in_ready,
  output logic [7:0]        rx_out_data,
  output logic              rx_out_valid,
  output logic              rx_out_last,
  output logic [PORT_W-1:0] rx_out_port,
  input  logic              rx_out_ready,
  output logic              rx_err
);

  // transmit: append one-hot tag after the last data byte
  logic       tx_mid, tx_mode, tx_pend;
  logic [7:0] tx_tag, tag_next;
  logic       tx_en, tx_acc;

  assign tx_en        = tx_mid ? tx_mode : cfg_tag_en;
  assign tx_out_valid = tx_pend | tx_in_valid;
  assign tx_out_data  = tx_pend ? tx_tag : tx_in_data;
  assign tx_out_last  = tx_pend | (tx_in_last & ~tx_en);
  assign tx_in_ready  = ~tx_pend & tx_out_ready;
  assign tx_acc       = tx_in_valid & tx_in_ready;

  always_comb begin
    tag_next = '0;
    for (int i = 0; i < NPORTS; i++)
      if (tx_in_dest == DEST_W'(i)) tag_next[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mid  <= 1'b0;
      tx_mode <= 1'b0;
      tx_pend <= 1'b0;
      tx_tag  <= '0;
    end else begin
      if (tx_pend && tx_out_ready) tx_pend <= 1'b0;
      if (tx_acc) begin
        if (!tx_mid) tx_mode <= cfg_tag_en;
        tx_mid <= ~tx_in_last;
        if (tx_in_last && tx_en) begin
          tx_pend <= 1'b1;
          tx_tag  <= tag_next;
        end
      end
    end
  end

  assert_tag_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc && tx_in_last && tx_en |=> tx_out_valid && tx_out_last && !tx_in_ready);
  assert_tag_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend |-> $onehot0(tx_out_data));
  assert_tag_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend && !tx_out_ready |=> tx_pend && $stable(tx_out_data));

  // receive: hold one byte back, strip trailing tag
  logic       rx_mid, rx_mode, rx_hold_vld;
  logic [7:0] rx_hold;
  logic       rx_en, rx_acc, rx_drop;

  assign rx_en        = rx_mid ? rx_mode : cfg_tag_en;
  assign rx_out_valid = rx_en ? (rx_hold_vld & rx_in_valid) : rx_in_valid;
  assign rx_out_data  = rx_en ? rx_hold : rx_in_data;
  assign rx_out_last  = rx_in_last;
  assign rx_out_port  = (rx_en & rx_in_last) ? rx_in_data[PORT_W-1:0] : '0;
  assign rx_in_ready  = rx_en ? (~rx_hold_vld | rx_out_ready) : rx_out_ready;
  assign rx_acc       = rx_in_valid & rx_in_ready;
  assign rx_drop      = rx_acc & rx_en & ~rx_hold_vld & rx_in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mid      <= 1'b0;
      rx_mode     <= 1'b0;
      rx_hold_vld <= 1'b0;
      rx_hold     <= '0;
      rx_err      <= 1'b0;
    end else begin
      rx_err <= rx_drop;
      if (rx_acc) begin
        if (!rx_mid) rx_mode <= cfg_tag_en;
        rx_mid <= ~rx_in_last;
        if (rx_en) begin
          rx_hold_vld <= ~rx_in_last;
          rx_hold     <= rx_in_data;
        end
      end
    end
  end

  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_err);
  assert_drop_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> !rx_out_valid);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold_vld && !rx_out_ready |=> $stable(rx_out_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_all_status <= 1'b0;
    else        pass_all_status <= cfg_pass_all;
  end

  assert_status_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pass_all_status == $past(cfg_pass_all));

endmodule

// File: tb/tail_tag_shim_tb_top.sv
module tail_tag_shim_tb_top;
  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0;
  logic cfg_tag_en = 0, cfg_pass_all = 0, pass_all_status;
  logic [7:0] tx_in_data = 0, tx_out_data, rx_in_data = 0, rx_out_data;
  logic tx_in_valid = 0, tx_in_last = 0, tx_in_ready;
  logic [1:0] tx_in_dest = 0;
  logic tx_out_valid, tx_out_last, tx_out_ready = 1;
  logic rx_in_valid = 0, rx_in_last = 0, rx_in_ready;
  logic rx_out_valid, rx_out_last, rx_out_ready = 1, rx_err;
  logic [2:0] rx_out_port;

  int checks = 0, failures = 0;
  int exp_err = 0, seen_err = 0;
  bit bp = 0;
  logic [8:0]  tx_q[$];
  logic [11:0] rx_q[$];

  always #2 clk = ~clk;

  tail_tag_shim dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // reference model fed at frame start; monitor compares every clock
  always @(negedge clk) begin
    tx_out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
    rx_out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (rst_n) begin
      if (tx_out_valid && tx_out_ready) begin
        if (tx_q.size() == 0) check(0, "R2/R4 extra tx beat", {tx_out_last, tx_out_data}, 0);
        else begin
          logic [8:0] e;
          e = tx_q.pop_front();
          check({tx_out_last, tx_out_data} == e, "R2/R3/R4/R10 tx beat", {tx_out_last, tx_out_data}, e);
        end
      end
      if (rx_out_valid && rx_out_ready) begin
        if (rx_q.size() == 0) check(0, "R5/R7 extra rx beat", {rx_out_port, rx_out_last, rx_out_data}, 0);
        else begin
          logic [11:0] e;
          e = rx_q.pop_front();
          check({rx_out_port, rx_out_last, rx_out_data} == e, "R5/R7/R10 rx beat",
                {rx_out_port, rx_out_last, rx_out_data}, e);
        end
      end
      if (rx_err) seen_err++;
    end
  end

  task automatic send_tx(input bq_t b, input int dest, input int flip_at);
    bit mode = cfg_tag_en;
    int n = b.size();
    bit acc;
    for (int i = 0; i < n; i++) tx_q.push_back({(i == n - 1) && !mode, b[i]});
    if (mode) tx_q.push_back({1'b1, (dest < 3) ? 8'(1 << dest) : 8'h00});
    for (int i = 0; i < n; i++) begin
      while (bp && ($urandom % 4 == 0)) @(negedge clk);
      if (i == flip_at) cfg_tag_en = ~cfg_tag_en;
      tx_in_valid = 1; tx_in_data = b[i]; tx_in_last = (i == n - 1); tx_in_dest = 2'(dest);
      do begin #1; acc = tx_in_ready; @(negedge clk); end while (!acc);
      tx_in_valid = 0;
    end
  endtask

  task automatic send_rx(input bq_t b, input int flip_at);
    bit mode = cfg_tag_en;
    int n = b.size();
    bit acc;
    if (mode) begin
      if (n == 1) exp_err++;
      for (int i = 0; i < n - 1; i++)
        rx_q.push_back({(i == n - 2) ? b[n-1][2:0] : 3'd0, i == n - 2, b[i]});
    end else
      for (int i = 0; i < n; i++) rx_q.push_back({3'd0, i == n - 1, b[i]});
    for (int i = 0; i < n; i++) begin
      while (bp && ($urandom % 4 == 0)) @(negedge clk);
      if (i == flip_at) cfg_tag_en = ~cfg_tag_en;
      rx_in_valid = 1; rx_in_data = b[i]; rx_in_last = (i == n - 1);
      do begin #1; acc = rx_in_ready; @(negedge clk); end while (!acc);
      rx_in_valid = 0;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && (tx_q.size() != 0 || rx_q.size() != 0); k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(tx_q.size() == 0, "R10 tx queue drained", tx_q.size(), 0);
    check(rx_q.size() == 0, "R10 rx queue drained", rx_q.size(), 0);
  endtask

  function automatic bq_t rnd_frame(input int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
    return q;
  endfunction

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfg_pass_all = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    check(!tx_out_valid && !rx_out_valid && !rx_err && !pass_all_status, "R1 reset state",
          {tx_out_valid, rx_out_valid, rx_err, pass_all_status}, 0);
    cfg_pass_all = 0;
    @(negedge clk); rst_n = 1;
    #1;
    check(!tx_out_valid && !rx_out_valid && !rx_err && !pass_all_status, "R1 after reset",
          {tx_out_valid, rx_out_valid, rx_err, pass_all_status}, 0);
    @(negedge clk);

    // R2 R3 R5 tagging on, no stalls
    cfg_tag_en = 1;
    send_tx('{8'h11, 8'h22, 8'h33}, 0, -1);
    send_tx('{8'h44, 8'h55}, 2, -1);
    send_tx('{8'h66}, 3, -1);                 // R3 out of range -> 00
    send_tx('{8'h77}, 1, -1);
    send_rx('{8'hA1, 8'hB2, 8'hC3, 8'hF9}, -1); // R5 upper bits ignored -> port 1
    send_rx('{8'h5A, 8'h02}, -1);
    send_rx('{8'hE0, 8'h07}, -1);
    // R6 lone tag dropped
    send_rx('{8'hFA}, -1);
    send_rx('{8'h03}, -1);
    drain();
    check(seen_err == exp_err, "R6 error pulses", seen_err, exp_err);

    // R10 backpressure with random traffic on both paths
    bp = 1;
    fork
      for (int f = 0; f < 40; f++) send_tx(rnd_frame(1 + $urandom % 6), $urandom % 4, -1);
      for (int f = 0; f < 40; f++) send_rx(rnd_frame(1 + $urandom % 6), -1);
    join
    drain();
    check(seen_err == exp_err, "R6 error pulses under stalls", seen_err, exp_err);

    // R4 R7 tagging off
    cfg_tag_en = 0;
    fork
      for (int f = 0; f < 20; f++) send_tx(rnd_frame(1 + $urandom % 5), $urandom % 3, -1);
      for (int f = 0; f < 20; f++) send_rx(rnd_frame(1 + $urandom % 5), -1);
    join
    send_rx('{8'h3C}, -1);                    // R7 one byte forwarded, no error
    drain();
    check(seen_err == exp_err, "R7 no error when off", seen_err, exp_err);

    // R8 mid-frame flips
    bp = 0;
    cfg_tag_en = 1;
    send_tx('{8'h01, 8'h02, 8'h03, 8'h04}, 1, 2);   // starts on, ends off: tag kept
    send_tx('{8'h05, 8'h06, 8'h07}, 0, 1);          // starts off, ends on: no tag
    send_rx('{8'h10, 8'h20, 8'h30}, 1);             // starts on
    send_rx('{8'h40, 8'h50, 8'h61}, 2);             // starts off
    drain();
    check(seen_err == exp_err, "R8 no spurious error", seen_err, exp_err);

    // R9 status lag
    @(negedge clk); cfg_pass_all = 1; #1;
    check(pass_all_status == 0, "R9 status before edge", pass_all_status, 0);
    @(negedge clk); #1;
    check(pass_all_status == 1, "R9 status after edge", pass_all_status, 1);
    cfg_pass_all = 0;
    @(negedge clk); #1;
    check(pass_all_status == 0, "R9 status clears", pass_all_status, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule